// File: doc/BRIEF.md
# SIMD Lane Predication Controller

This block steers a group of SIMD lanes that all follow one shared program counter. Instead of letting lanes jump to different addresses, every lane holds a single enable bit, and only lanes whose bit is set are allowed to commit results. Structured control opcodes arrive one per cycle together with a per-lane condition vector. The block narrows, flips, widens or restores the enable bits so that nested conditionals and loops behave as if each lane had its own branch unit.

Entering a conditional or a loop saves the controller state in a frame on an internal stack. Leaving the construct takes that frame back off. Inside a loop, two lane sets are tracked: lanes that have left the loop for good, and lanes that have only skipped the rest of the current pass. When a loop end is reached, the block tells the instruction sequencer in the same cycle whether to jump back to the loop head. It jumps back while any lane still wants another pass, and falls through once none does. Stack misuse sets a sticky fault and leaves the lane state untouched.

Top module: `lane_mask_ctrl`

## Requirements
- R1: Reset (synchronous, active high) makes every lane active, empties the stack and clears the fault flag.
- R2: The opcode input is encoded as 0 no-op, 1 open-conditional, 2 else, 3 close-conditional, 4 open-loop, 5 break, 6 continue, 7 close-loop. Bit i of the condition and mask vectors belongs to lane i. Open-conditional saves a frame and sets the mask to the current mask AND the condition.
- R3: Else sets the mask to the saved mask with the currently active, broken and continued lanes removed.
- R4: Close-conditional drops the top frame and sets the mask to the saved mask with the broken and continued lanes of the innermost loop removed.
- R5: Open-loop saves a frame, keeps the mask unchanged and starts the new loop with empty broken and continued sets.
- R6: Break removes the active lanes whose condition bit is set, both from the mask and from every later pass of the loop.
- R7: Continue removes the active lanes whose condition bit is set for the rest of the current pass only. They rejoin when the loop goes back to its head.
- R8: On close-loop, loop_back_o is high in the same cycle exactly when the union of the active and continued lanes is non-zero. In that case the mask becomes that union, the continued set is cleared and the frame stays.
- R9: On close-loop with no active or continued lane, the frame is dropped, and the mask, broken set and continued set return to their values from before the loop opened.
- R10: Open-conditional or open-loop with DEPTH frames already stored sets the fault flag and changes no lane state.
- R11: Else, close-conditional or close-loop on an empty stack sets the fault flag, changes no lane state and keeps loop_back_o low.
- R12: The no-op code leaves the mask, the fault flag and the stack unchanged.
- R13: The fault flag, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Control opcode for this cycle |
| cond_i | input | LANES | Per-lane condition vector |
| mask_o | output | LANES | Current per-lane active mask |
| loop_back_o | output | 1 | Close-loop decision: 1 jumps to the loop head, 0 falls through |
| fault_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
At close-loop, the loop-back decision and the frame pop compete in the same cycle. The delicate case is a pass in which every live lane has either continued or broken, so the active mask is zero while the continued set is not. The bench provokes this by continuing every lane and then closing the loop, which must jump back with the continued lanes revived and the frame kept. It then breaks every lane and closes again, which must exit and restore the mask from before the loop. A sweep over all ordered pairs of opcodes inside an open loop-and-conditional nest, plus a long pseudo-random opcode stream, compares every cycle against an arithmetic model derived from the requirements.

// File: rtl/lane_mask_pkg.sv
package lane_mask_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_IF      = 3'd1,
        OP_ELSE    = 3'd2,
        OP_ENDIF   = 3'd3,
        OP_LOOP    = 3'd4,
        OP_BREAK   = 3'd5,
        OP_CONT    = 3'd6,
        OP_ENDLOOP = 3'd7
    } mctl_op_e;

    // opcodes that open a construct and save a frame
    function automatic logic op_opens(mctl_op_e op);
        return (op == OP_IF) || (op == OP_LOOP);
    endfunction

    // opcodes that need a saved frame to act on
    function automatic logic op_reads_frame(mctl_op_e op);
        return (op == OP_ELSE) || (op == OP_ENDIF) || (op == OP_ENDLOOP);
    endfunction

endpackage

// File: rtl/lane_frame_stack.sv
module lane_frame_stack #(
    parameter int W     = 48,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 top,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   cnt
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  slot [DEPTH];
    logic [CW-1:0] cnt_q;

    assign cnt   = cnt_q;
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);

    // one register row per slot, written when the pointer lands on it
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[i] <= '0;
            end else if (push && (cnt_q == CW'(i))) begin
                slot[i] <= din;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        if (empty) begin
            top = '0;
        end else begin
            top = slot[AW'(cnt_q - 1'b1)];
        end
    end

endmodule

// File: rtl/lane_mask_next.sv
module lane_mask_next
    import lane_mask_pkg::*;
#(
    parameter int LANES = 16
) (
    input  mctl_op_e         op,
    input  logic [LANES-1:0] cond,
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] cur_brk,
    input  logic [LANES-1:0] cur_cont,
    input  logic [LANES-1:0] top_mask,
    input  logic [LANES-1:0] top_brk,
    input  logic [LANES-1:0] top_cont,
    input  logic             full,
    input  logic             empty,
    output logic [LANES-1:0] nxt_mask,
    output logic [LANES-1:0] nxt_brk,
    output logic [LANES-1:0] nxt_cont,
    output logic             push,
    output logic             pop,
    output logic             bad,
    output logic             loop_back
);
    logic [LANES-1:0] live;
    logic [LANES-1:0] hit;

    assign live = cur_mask | cur_cont;
    assign hit  = cur_mask & cond;

    always_comb begin
        nxt_mask  = cur_mask;
        nxt_brk   = cur_brk;
        nxt_cont  = cur_cont;
        push      = 1'b0;
        pop       = 1'b0;
        loop_back = 1'b0;
        bad       = (op_opens(op) && full) || (op_reads_frame(op) && empty);
        if (!bad) begin
            case (op)
                OP_IF: begin
                    push     = 1'b1;
                    nxt_mask = hit;
                end
                OP_ELSE: begin
                    nxt_mask = top_mask & ~(cur_mask | cur_brk | cur_cont);
                end
                OP_ENDIF: begin
                    pop      = 1'b1;
                    nxt_mask = top_mask & ~cur_brk & ~cur_cont;
                end
                OP_LOOP: begin
                    push     = 1'b1;
                    nxt_brk  = '0;
                    nxt_cont = '0;
                end
                OP_BREAK: begin
                    nxt_brk  = cur_brk | hit;
                    nxt_mask = cur_mask & ~cond;
                end
                OP_CONT: begin
                    nxt_cont = cur_cont | hit;
                    nxt_mask = cur_mask & ~cond;
                end
                OP_ENDLOOP: begin
                    if (|live) begin
                        loop_back = 1'b1;
                        nxt_mask  = live;
                        nxt_cont  = '0;
                    end else begin
                        pop      = 1'b1;
                        nxt_mask = top_mask;
                        nxt_brk  = top_brk;
                        nxt_cont = top_cont;
                    end
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/lane_mask_ctrl.sv
module lane_mask_ctrl
    import lane_mask_pkg::*;
#(
    parameter int LANES = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_i,
    input  logic [LANES-1:0] cond_i,
    output logic [LANES-1:0] mask_o,
    output logic             loop_back_o,
    output logic             fault_o
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic [LANES-1:0] brk;
        logic [LANES-1:0] cont;
    } frame_t;

    localparam int FW = $bits(frame_t);

    frame_t           cur_q;
    frame_t           nxt;
    frame_t           top_f;
    logic [FW-1:0]    top_bits;
    logic             fault_q;
    logic             stk_push;
    logic             stk_pop;
    logic             stk_full;
    logic             stk_empty;
    logic             op_bad;
    logic             lb;
    logic [CW-1:0]    stk_cnt;
    mctl_op_e         op;

    assign op    = mctl_op_e'(op_i);
    assign top_f = frame_t'(top_bits);

    lane_frame_stack #(
        .W     (FW),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (cur_q),
        .top   (top_bits),
        .full  (stk_full),
        .empty (stk_empty),
        .cnt   (stk_cnt)
    );

    lane_mask_next #(
        .LANES (LANES)
    ) u_next (
        .op        (op),
        .cond      (cond_i),
        .cur_mask  (cur_q.mask),
        .cur_brk   (cur_q.brk),
        .cur_cont  (cur_q.cont),
        .top_mask  (top_f.mask),
        .top_brk   (top_f.brk),
        .top_cont  (top_f.cont),
        .full      (stk_full),
        .empty     (stk_empty),
        .nxt_mask  (nxt.mask),
        .nxt_brk   (nxt.brk),
        .nxt_cont  (nxt.cont),
        .push      (stk_push),
        .pop       (stk_pop),
        .bad       (op_bad),
        .loop_back (lb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.mask <= '1;
            cur_q.brk  <= '0;
            cur_q.cont <= '0;
            fault_q    <= 1'b0;
        end else begin
            cur_q <= nxt;
            if (op_bad) begin
                fault_q <= 1'b1;
            end
        end
    end

    assign mask_o      = cur_q.mask;
    assign loop_back_o = lb;
    assign fault_o     = fault_q;

endmodule

// File: rtl/lane_mask_chk.sv
module lane_mask_chk #(
    parameter int LANES = 16,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic [2:0]                 op_i,
    input logic [LANES-1:0]           cond_i,
    input logic [LANES-1:0]           mask_o,
    input logic                       loop_back_o,
    input logic                       fault_o,
    input logic                       stk_full,
    input logic                       stk_empty,
    input logic [$clog2(DEPTH+1)-1:0] stk_cnt
);
    AST_RESET_ALL_ON: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((&mask_o) && !fault_o && stk_empty)); // R1

    AST_IF_NARROWS: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd1 && !stk_full) |=> (mask_o == $past(mask_o & cond_i))); // R2

    AST_BREAK_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd5) |=> ((mask_o & ~$past(mask_o)) == '0)); // R6

    AST_LOOPBACK_LIVE: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd7 && loop_back_o) |=> (mask_o != '0 && $stable(stk_cnt))); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        ((op_i == 3'd1 || op_i == 3'd4) && stk_full) |=> ($stable(mask_o) && fault_o && $stable(stk_cnt))); // R10

    AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd7) && stk_empty) |-> !loop_back_o); // R11

    AST_NOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0) |=> ($stable(mask_o) && $stable(stk_cnt))); // R12

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> fault_o); // R13

endmodule

bind lane_mask_ctrl lane_mask_chk #(
    .LANES (LANES),
    .DEPTH (DEPTH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_i        (op_i),
    .cond_i      (cond_i),
    .mask_o      (mask_o),
    .loop_back_o (loop_back_o),
    .fault_o     (fault_o),
    .stk_full    (stk_full),
    .stk_empty   (stk_empty),
    .stk_cnt     (stk_cnt)
);

// File: tb/lane_mask_ctrl_tb.sv
`timescale 1ns/1ps
module lane_mask_ctrl_tb;
    localparam int LANES = 16;
    localparam int DEPTH = 8;
    localparam logic [LANES-1:0] ALL = '1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       op_i = 3'd0;
    logic [LANES-1:0] cond_i = '0;
    logic [LANES-1:0] mask_o;
    logic             loop_back_o;
    logic             fault_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state, derived from the requirements
    logic [LANES-1:0] m_mask, m_brk, m_cont;
    logic [LANES-1:0] s_mask [DEPTH];
    logic [LANES-1:0] s_brk  [DEPTH];
    logic [LANES-1:0] s_cont [DEPTH];
    int               m_cnt;
    logic             m_fault;
    logic [31:0]      rng = 32'h1234_5678;

    always #4 clk = ~clk;

    lane_mask_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .op_i        (op_i),
        .cond_i      (cond_i),
        .mask_o      (mask_o),
        .loop_back_o (loop_back_o),
        .fault_o     (fault_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R12 nop";
            3'd1: return "R2 open-cond";
            3'd2: return "R3 else";
            3'd3: return "R4 close-cond";
            3'd4: return "R5 open-loop";
            3'd5: return "R6 break";
            3'd6: return "R7 continue";
            default: return "R8/R9 close-loop";
        endcase
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // reset: expects all lanes on, empty stack, no fault (R1)
    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        op_i = 3'd0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_mask = ALL; m_brk = '0; m_cont = '0; m_cnt = 0; m_fault = 1'b0;
        chk(mask_o == ALL, "R1 reset mask", 64'(mask_o), 64'(ALL));
        chk(fault_o == 1'b0, "R1 reset fault", 64'(fault_o), 64'd0);
    endtask

    // one opcode: driven at a falling edge, results sampled at the next one
    task automatic step(input logic [2:0] op, input logic [LANES-1:0] c);
        bit bad;
        bit elb;
        logic [LANES-1:0] live;
        string t;
        t = tag_of(op);
        op_i   = op;
        cond_i = c;
        live = m_mask | m_cont;
        bad  = ((op == 3'd1 || op == 3'd4) && m_cnt == DEPTH) ||
               ((op == 3'd2 || op == 3'd3 || op == 3'd7) && m_cnt == 0);
        elb  = !bad && op == 3'd7 && (live != '0);
        #1;
        chk(loop_back_o == elb, bad ? "R11 loop_back on underflow" : "R8 loop_back",
            64'(loop_back_o), 64'(elb));
        if (bad) begin
            m_fault = 1'b1;
            t = (op == 3'd1 || op == 3'd4) ? "R10 overflow" : "R11 underflow";
        end else begin
            case (op)
                3'd1: begin
                    s_mask[m_cnt] = m_mask; s_brk[m_cnt] = m_brk; s_cont[m_cnt] = m_cont;
                    m_cnt++;
                    m_mask = m_mask & c;
                end
                3'd2: m_mask = s_mask[m_cnt-1] & ~m_mask & ~m_brk & ~m_cont;
                3'd3: begin
                    m_cnt--;
                    m_mask = s_mask[m_cnt] & ~m_brk & ~m_cont;
                end
                3'd4: begin
                    s_mask[m_cnt] = m_mask; s_brk[m_cnt] = m_brk; s_cont[m_cnt] = m_cont;
                    m_cnt++;
                    m_brk = '0; m_cont = '0;
                end
                3'd5: begin
                    m_brk  = m_brk | (m_mask & c);
                    m_mask = m_mask & ~c;
                end
                3'd6: begin
                    m_cont = m_cont | (m_mask & c);
                    m_mask = m_mask & ~c;
                end
                3'd7: begin
                    if (elb) begin
                        m_mask = live; m_cont = '0;
                    end else begin
                        m_cnt--;
                        m_mask = s_mask[m_cnt]; m_brk = s_brk[m_cnt]; m_cont = s_cont[m_cnt];
                    end
                end
                default: ;
            endcase
        end
        @(negedge clk);
        chk(mask_o == m_mask, t, 64'(mask_o), 64'(m_mask));
        chk(fault_o == m_fault, "R13 fault flag", 64'(fault_o), 64'(m_fault));
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R12: no-op keeps everything
        step(3'd0, 16'hFFFF);
        chk(mask_o == ALL, "R12 nop mask", 64'(mask_o), 64'(ALL));

        // R2, R3, R4: simple conditional
        step(3'd1, 16'h00FF);
        chk(mask_o == 16'h00FF, "R2 if mask", 64'(mask_o), 64'h00FF);
        step(3'd2, 16'h0000);
        chk(mask_o == 16'hFF00, "R3 else mask", 64'(mask_o), 64'hFF00);
        step(3'd3, 16'h0000);
        chk(mask_o == ALL, "R4 endif mask", 64'(mask_o), 64'(ALL));

        // R5..R9: loop with break and continue
        step(3'd4, 16'h0000);
        chk(mask_o == ALL, "R5 loop mask", 64'(mask_o), 64'(ALL));
        step(3'd5, 16'h000F);
        step(3'd6, 16'h00F0);
        chk(mask_o == 16'hFF00, "R7 continue mask", 64'(mask_o), 64'hFF00);
        step(3'd7, 16'h0000);
        chk(mask_o == 16'hFFF0, "R6 broken lanes stay out", 64'(mask_o), 64'hFFF0);

        // loop-back and pop compete: all live lanes continued
        step(3'd6, 16'hFFFF);
        chk(mask_o == 16'h0000, "R7 all continued", 64'(mask_o), 64'h0);
        step(3'd7, 16'h0000);
        chk(mask_o == 16'hFFF0, "R8 revive continued", 64'(mask_o), 64'hFFF0);
        step(3'd5, 16'hFFFF);
        step(3'd7, 16'h0000);
        chk(mask_o == ALL, "R9 loop exit restores", 64'(mask_o), 64'(ALL));

        // break inside a conditional inside a loop, then close-conditional
        step(3'd4, 16'h0);
        step(3'd1, 16'h0F0F);
        step(3'd5, 16'h0303);
        step(3'd2, 16'h0);
        chk(mask_o == 16'hF0F0, "R3 else after break", 64'(mask_o), 64'hF0F0);
        step(3'd3, 16'h0);
        chk(mask_o == 16'hFCFC, "R4 endif drops broken", 64'(mask_o), 64'hFCFC);
        step(3'd5, 16'hFFFF);
        step(3'd7, 16'h0);
        chk(mask_o == ALL, "R9 exit after nested break", 64'(mask_o), 64'(ALL));

        // R10: overflow
        for (int i = 0; i < DEPTH; i++) step(3'd1, 16'hFFFF);
        step(3'd4, 16'h0);
        chk(fault_o == 1'b1, "R10 overflow fault", 64'(fault_o), 64'd1);
        step(3'd0, 16'h0);
        chk(fault_o == 1'b1, "R13 sticky fault", 64'(fault_o), 64'd1);

        // R11: underflow
        do_reset();
        step(3'd7, 16'h0);
        chk(fault_o == 1'b1, "R11 underflow fault", 64'(fault_o), 64'd1);
        chk(mask_o == ALL, "R11 mask held", 64'(mask_o), 64'(ALL));

        // sweep: every ordered opcode pair inside an open loop and conditional
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                do_reset();
                step(3'd4, 16'h0);
                step(3'd1, 16'h0F0F);
                step(3'(a), 16'h3355);
                step(3'(b), 16'h5A0F);
                step(3'd3, 16'h0);
                step(3'd7, 16'h0);
            end
        end

        // pseudo-random opcode stream with periodic reset
        for (int n = 0; n < 4000; n++) begin
            if ((n % 250) == 0) do_reset();
            rng = next_rng(rng);
            step(rng[2:0], rng[31:16]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule